// File: doc/BRIEF.md
# Attack-Driven Protection Level Controller

This block keeps one protection level for each peripheral that sits behind a bus firewall. When a firewall reports an attack, the peripheral behind it is degraded at once. A peripheral marked critical is cut off: every access is answered with a fixed error code. Any other peripheral keeps read access but loses write access. After a programmable stretch of attack-free cycles the peripheral returns by itself to its programmed policy. A stretch length of zero turns this automatic return off.

Every attack also sets a bit in a sticky status register, one bit per firewall. Any set bit raises an interrupt request toward a trusted reconfiguration processor. When that processor acknowledges the interrupt, every flagged firewall enters a reconfiguration phase. In that phase its reconfiguration-enable bit is high and accesses to the peripheral are held off. The phase ends when the processor signals that the policy rewrite for that firewall is done.

Each firewall runs its own state machine with four states. OPEN applies the programmed policy. ISOLATE answers with the error code. READ_ONLY blocks writes. RECONFIG holds accesses off while the policy is rewritten. The transitions are:
- attack-critical: OPEN to ISOLATE.
- attack-plain: OPEN to READ_ONLY.
- escalate: READ_ONLY to ISOLATE.
- quiet-expire: ISOLATE or READ_ONLY to OPEN.
- ack-enter: any state except RECONFIG to RECONFIG.
- rewrite-done: RECONFIG to OPEN.

Top module: `prot_level_ctrl`

## Requirements
- R1: After reset every level output is OPEN (code 2'b00), `irq_o` is 0, `recfg_en_o` is all 0 and `attack_status_o` is all 0.
- R2: An attack on an OPEN firewall whose `critical_i` bit is 1 makes its level ISOLATE (error-code level, code 2'b11) from the next clock edge.
- R3: An attack on an OPEN firewall whose `critical_i` bit is 0 makes its level READ_ONLY (code 2'b01) from the next clock edge.
- R4: With a quiet length L > 0 loaded at the last attack, a degraded firewall returns to OPEN exactly L clock edges after the last edge at which an attack was sampled.
- R5: An attack that arrives while a firewall is degraded reloads the quiet countdown to the full length presented on `quiet_len_i` at that edge.
- R6: If the quiet length loaded at the last attack is 0, a degraded firewall stays degraded until it enters reconfiguration.
- R7: Bit i of `attack_status_o` is set at the edge after an attack on firewall i. It stays set until an edge with `irq_ack_i` high, and an attack at that same edge wins over the clear. `irq_o` is high whenever any status bit is set.
- R8: At an edge with `irq_ack_i` high, every firewall whose status bit was set and which is not already in RECONFIG enters RECONFIG. In RECONFIG its `recfg_en_o` bit is 1 and its level is HOLD (code 2'b10). Attacks do not move it. It returns to OPEN at the edge after its `recfg_done_i` bit is 1.
- R9: A READ_ONLY firewall that sees an attack while its `critical_i` bit is 1 escalates to ISOLATE at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attack_i | input | N_FW | Attack flag per firewall |
| critical_i | input | N_FW | Criticality setting per peripheral |
| quiet_len_i | input | CNT_W | Quiet window length in cycles, 0 disables recovery |
| irq_ack_i | input | 1 | Interrupt acknowledge from the reconfiguration processor |
| recfg_done_i | input | N_FW | Policy rewrite finished, per firewall |
| prot_level_o | output | 2*N_FW | Effective level per firewall, 2 bits each, firewall i at [2i+1:2i] |
| recfg_en_o | output | N_FW | Reconfiguration enable per firewall |
| irq_o | output | 1 | Interrupt request |
| attack_status_o | output | N_FW | Sticky attack status per firewall |

## Verification
The hardest situations to reach are edges where several events coincide. One is an acknowledge arriving in the same cycle as a new attack. Another is an attack landing in the last cycle of a quiet countdown. A third is an escalation racing a recovery. The stimulus draws sparse attacks, random criticality, short quiet lengths (including zero), and frequent acknowledge and done pulses for thousands of cycles, so these overlaps happen many times. A bench model tracks every firewall at every edge. Directed sequences first pin down the exact recovery edge, the reload, the zero-length case, escalation and the reconfiguration hold.

// File: rtl/prot_level_pkg.sv
package prot_level_pkg;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_RDONLY = 2'd1,
        ST_ISOL   = 2'd2,
        ST_RECFG  = 2'd3
    } fw_state_t;

    typedef enum logic [1:0] {
        LVL_OPEN   = 2'b00,
        LVL_RDONLY = 2'b01,
        LVL_HOLD   = 2'b10,
        LVL_ERRCODE = 2'b11
    } prot_level_t;

endpackage

// File: rtl/prot_fw_fsm.sv
module prot_fw_fsm
    import prot_level_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             attack_i,
    input  logic             critical_i,
    input  logic [CNT_W-1:0] quiet_len_i,
    input  logic             go_recfg_i,
    input  logic             recfg_done_i,
    output prot_level_t      level_o,
    output logic             recfg_en_o
);

    fw_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OPEN: begin
                if (go_recfg_i) begin
                    state_d = ST_RECFG;
                end else if (attack_i) begin
                    state_d = critical_i ? ST_ISOL : ST_RDONLY;
                    cnt_d   = quiet_len_i;
                end
            end
            ST_RDONLY, ST_ISOL: begin
                if (go_recfg_i) begin
                    state_d = ST_RECFG;
                    cnt_d   = '0;
                end else if (attack_i) begin
                    cnt_d = quiet_len_i;
                    if (critical_i) state_d = ST_ISOL;
                end else if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_OPEN;
                    cnt_d   = '0;
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_RECFG: begin
                cnt_d = '0;
                if (recfg_done_i) state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN:   begin level_o = LVL_OPEN;    recfg_en_o = 1'b0; end
            ST_RDONLY: begin level_o = LVL_RDONLY;  recfg_en_o = 1'b0; end
            ST_ISOL:   begin level_o = LVL_ERRCODE; recfg_en_o = 1'b0; end
            ST_RECFG:  begin level_o = LVL_HOLD;    recfg_en_o = 1'b1; end
            default:   begin level_o = LVL_OPEN;    recfg_en_o = 1'b0; end
        endcase
    end

    p_isolate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == LVL_OPEN && attack_i && critical_i && !go_recfg_i)
        |=> level_o == LVL_ERRCODE);

    p_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == LVL_OPEN && attack_i && !critical_i && !go_recfg_i)
        |=> level_o == LVL_RDONLY);

    p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ISOL || state_q == ST_RDONLY) && cnt_q == '0
         && !attack_i && !go_recfg_i)
        |=> $stable(level_o));

    p_escalate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == LVL_RDONLY && attack_i && critical_i && !go_recfg_i)
        |=> level_o == LVL_ERRCODE);

    p_recfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECFG && !recfg_done_i) |=> (recfg_en_o && level_o == LVL_HOLD));

endmodule

// File: rtl/prot_irq_status.sv
module prot_irq_status #(
    parameter int N_FW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_FW-1:0] attack_i,
    input  logic            irq_ack_i,
    output logic [N_FW-1:0] status_o,
    output logic [N_FW-1:0] go_recfg_o,
    output logic            irq_o
);

    logic [N_FW-1:0] status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~{N_FW{irq_ack_i}}) | attack_i;
    end

    assign status_o   = status_q;
    assign go_recfg_o = status_q & {N_FW{irq_ack_i}};
    assign irq_o      = |status_q;

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack_i |=> ((status_o & $past(status_o)) == $past(status_o)));

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|attack_i));

endmodule

// File: rtl/prot_level_ctrl.sv
module prot_level_ctrl
    import prot_level_pkg::*;
#(
    parameter int N_FW  = 4,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FW-1:0]   attack_i,
    input  logic [N_FW-1:0]   critical_i,
    input  logic [CNT_W-1:0]  quiet_len_i,
    input  logic              irq_ack_i,
    input  logic [N_FW-1:0]   recfg_done_i,
    output logic [2*N_FW-1:0] prot_level_o,
    output logic [N_FW-1:0]   recfg_en_o,
    output logic              irq_o,
    output logic [N_FW-1:0]   attack_status_o
);

    logic [N_FW-1:0] go_recfg;

    prot_irq_status #(.N_FW(N_FW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .attack_i   (attack_i),
        .irq_ack_i  (irq_ack_i),
        .status_o   (attack_status_o),
        .go_recfg_o (go_recfg),
        .irq_o      (irq_o)
    );

    for (genvar g = 0; g < N_FW; g++) begin : g_fw
        prot_level_t lvl;
        prot_fw_fsm #(.CNT_W(CNT_W)) u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .attack_i     (attack_i[g]),
            .critical_i   (critical_i[g]),
            .quiet_len_i  (quiet_len_i),
            .go_recfg_i   (go_recfg[g]),
            .recfg_done_i (recfg_done_i[g]),
            .level_o      (lvl),
            .recfg_en_o   (recfg_en_o[g])
        );
        assign prot_level_o[2*g +: 2] = lvl;
    end

    p_irq_matches_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|attack_i) |=> irq_o);

endmodule

// File: tb/prot_level_ctrl_bench.sv
module prot_level_ctrl_bench;

    localparam int N_FW = 4;
    localparam int CNT_W = 16;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_FW-1:0] attack = '0, critical = '0, done = '0;
    logic [CNT_W-1:0] qlen = '0;
    logic ack = 1'b0;
    logic [2*N_FW-1:0] level;
    logic [N_FW-1:0] recfg_en, status;
    logic irq;

    int checks = 0, failures = 0;
    int m_st [N_FW];
    int m_cnt [N_FW];
    logic [N_FW-1:0] m_status;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_level_ctrl #(.N_FW(N_FW), .CNT_W(CNT_W)) u_prot_level_ctrl (
        .clk(clk), .rst_n(rst_n), .attack_i(attack), .critical_i(critical),
        .quiet_len_i(qlen), .irq_ack_i(ack), .recfg_done_i(done),
        .prot_level_o(level), .recfg_en_o(recfg_en), .irq_o(irq),
        .attack_status_o(status)
    );

    // model states: 0 open, 1 read-only, 2 isolate, 3 reconfig
    function automatic logic [1:0] lvl_of(int st);
        case (st)
            1: return 2'b01;
            2: return 2'b11;
            3: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic string req_of(int st);
        case (st)
            1: return "R3";
            2: return "R2";
            3: return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N_FW; i++) begin m_st[i] = 0; m_cnt[i] = 0; end
        m_status = '0;
    endtask

    task automatic model_step();
        for (int i = 0; i < N_FW; i++) begin
            logic go;
            go = ack && m_status[i];
            case (m_st[i])
                0: if (go) m_st[i] = 3;
                   else if (attack[i]) begin m_st[i] = critical[i] ? 2 : 1; m_cnt[i] = qlen; end
                1, 2: if (go) begin m_st[i] = 3; m_cnt[i] = 0; end
                   else if (attack[i]) begin m_cnt[i] = qlen; if (critical[i]) m_st[i] = 2; end
                   else if (m_cnt[i] == 1) begin m_st[i] = 0; m_cnt[i] = 0; end
                   else if (m_cnt[i] != 0) m_cnt[i]--;
                default: begin m_cnt[i] = 0; if (done[i]) m_st[i] = 0; end
            endcase
        end
        m_status = (ack ? '0 : m_status) | attack;
    endtask

    task automatic compare_all();
        for (int i = 0; i < N_FW; i++) begin
            check(req_of(m_st[i]), level[2*i +: 2], lvl_of(m_st[i]));
            check("R8", recfg_en[i], m_st[i] == 3);
        end
        check("R7", status, m_status);
        check("R7", irq, |m_status);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        attack = '0; ack = 1'b0; done = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", level, '0);
        check("R1", irq, 0);
        check("R1", recfg_en, '0);
        check("R1", status, '0);

        // R2 / R3: critical fw0 and plain fw1
        qlen = 3; critical = 4'b0001; attack = 4'b0011;
        tick();
        check("R2", level[1:0], 2'b11);
        check("R3", level[3:2], 2'b01);
        check("R7", status, 4'b0011);
        check("R7", irq, 1);
        quiet();
        tick(); tick();
        check("R4", level[1:0], 2'b11);
        tick();
        check("R4", level[1:0], 2'b00);
        check("R4", level[3:2], 2'b00);

        // R5: reload during window
        attack = 4'b0001; tick(); quiet();
        tick(); tick();
        attack = 4'b0001; qlen = 3; tick(); quiet();
        tick(); tick();
        check("R5", level[1:0], 2'b11);
        tick();
        check("R5", level[1:0], 2'b00);

        // R9: escalation of read-only fw1
        critical = 4'b0000; attack = 4'b0010; tick();
        check("R9", level[3:2], 2'b01);
        critical = 4'b0010; tick(); quiet();
        check("R9", level[3:2], 2'b11);

        // R6: zero length disables recovery
        qlen = 0; critical = 4'b0000; attack = 4'b0100; tick(); quiet();
        repeat (10) tick();
        check("R6", level[5:4], 2'b01);

        // R8: acknowledge enters reconfiguration; attack ignored there
        ack = 1'b1; tick(); ack = 1'b0;
        check("R8", recfg_en[2], 1);
        check("R8", level[5:4], 2'b10);
        check("R7", irq, 0);
        attack = 4'b0100; tick(); attack = '0;
        check("R8", level[5:4], 2'b10);
        done = 4'b0100; tick(); done = '0;
        check("R8", level[5:4], 2'b00);
        check("R8", recfg_en[2], 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < N_FW; i++) begin
                attack[i] = ($urandom % 12) == 0;
                critical[i] = $urandom % 2;
                done[i] = ($urandom % 4) == 0;
            end
            ack = ($urandom % 10) == 0;
            if (($urandom % 16) == 0) qlen = CNT_W'($urandom % 7);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule